// File: doc/BRIEF.md
# Debug Host Breakpoint and Shift Clock Controller

This block sits on the host side of a serial debug link. It owns one output line that does two jobs. While no transfer is running, the line is the target's active-low breakpoint request. Once the target is halted, the same line is the serial shift clock. The host issues a command while the block is idle. The command either requests a breakpoint or shifts one 17-bit frame to and from the target.

A breakpoint can be requested in two ways. In force mode the line goes low at once and stays low until the target reports that it is frozen; no bus activity needs to be watched. In tag mode the block waits for the next bus cycle that the host marks with a strobe, and pulls the line low for exactly that cycle. If both request flags are set, force mode wins.

A shift command sends the frame MSB first on the serial data input while capturing the target's serial output on each rising clock edge. The low and high clock phases are set by a programmable divider. After the last rising edge the line stays high, so the prefetch at session exit cannot be tagged. The block then waits for the target's data output to change state before reporting completion. A counter bounds that wait and raises a time-out flag if the change never arrives.

Top module: `dbgh_ctrl`

## Requirements
- R1: After reset, `bkpt_clk_n` is 1, `dsi` is 0, and `busy`, `done` and `timeout` are 0.
- R2: An accepted command with `cmd_force`=1 drives `bkpt_clk_n` low from the next clock. The line stays low until `freeze` is sampled high. On the clock after that, the line returns high, `busy` falls and `done` is 1.
- R3: An accepted command with `cmd_tag`=1 (and `cmd_force`=0) waits for the first rising edge of `bus_cyc` seen after acceptance; a cycle already in progress at acceptance is not tagged. `bkpt_clk_n` is then low for exactly as many clocks as `bus_cyc` stays high, delayed by one clock. `done` is 1 on the clock where the line returns high, and later bus cycles are not tagged.
- R4: When `cmd_force` and `cmd_tag` are both 1, the command behaves exactly as force mode.
- R5: An accepted command with both flags 0 shifts a frame. The line starts low on the next clock and makes 17 low phases and 17 high phases, alternating. Each phase lasts `cfg_half`+1 clocks.
- R6: `dsi` carries `cmd_data` MSB first. It changes only on the clock where the line falls and is stable while the line is high.
- R7: At each rising edge of the line, `dso` is shifted into `rx_data` from the LSB end. After a frame, `rx_data` holds the 17 target bits with the first one in bit 16.
- R8: After the 17th rising edge, the line stays high until the next command.
- R9: Call the clock of the 17th rising edge clock 0. If `dso` first differs at clock k from its value at clock 0, and k is at most TMO_CYC, then on clock k `busy` falls and `done` is 1.
- R10: If `dso` does not change during clocks 1..TMO_CYC, then at clock TMO_CYC `timeout` rises, `busy` falls and `done` stays 0. `timeout` then holds until the next accepted command clears it.
- R11: `cmd_valid` while `busy` is 1 is ignored.
- R12: `done` is high for a single clock per completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_force | input | 1 | Request breakpoint by holding the line until frozen |
| cmd_tag | input | 1 | Request breakpoint on the next marked bus cycle |
| cmd_data | input | FRAME_W | Frame to shift when neither flag is set |
| cfg_half | input | DIV_W | Clock phase length minus one, in system clocks |
| bus_cyc | input | 1 | High for the duration of the bus cycle to tag |
| freeze | input | 1 | Target halted indication |
| dso | input | 1 | Target serial data output |
| bkpt_clk_n | output | 1 | Combined active-low breakpoint and shift clock line |
| dsi | output | 1 | Serial data to the target |
| rx_data | output | FRAME_W | Last frame captured from the target |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | Sticky flag: wait for the target's data-output change expired |

## Verification
The assertions check on every cycle the properties that hold locally. They confirm that `dsi` is steady while the line is high, that the line is high throughout the wait for `dso`, and that a tagged low level only follows a high bus strobe. They also check that force mode releases the line on the clock after `freeze`, that `done` lasts one clock, and that the wait counter never passes its limit. Only the bench's scenarios can show the properties that depend on whole sequences. These are the exact phase lengths across divider settings, the bit order in both directions, and the exact clock on which `done` or `timeout` appears at the time-out boundary. The bench also shows that commands issued while busy leave no trace and that a bus cycle already running at arming time is skipped.

// File: rtl/dbgh_pkg.sv
package dbgh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FORCE,
        ST_TAG_WAIT,
        ST_TAG_LOW,
        ST_SH_LO,
        ST_SH_HI,
        ST_WAIT_DSO
    } dbgh_state_e;
endpackage

// File: rtl/dbgh_phase_div.sv
module dbgh_phase_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             phase_end
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    // a phase ends once the counter has spent half+1 clocks in it
    assign phase_end = run && (cnt_q == half);

    always_comb begin
        cnt_d = cnt_q;
        if (restart || phase_end) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dbgh_timeout.sv
module dbgh_timeout #(
    parameter int LIMIT = 1000,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expire = run && (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        cnt_d = '0;
        if (run && !expire) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT - 1)); // R10
endmodule

// File: rtl/dbgh_ctrl.sv
module dbgh_ctrl
    import dbgh_pkg::*;
#(
    parameter int FRAME_W = 17,
    parameter int DIV_W   = 4,
    parameter int TMO_CYC = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_force,
    input  logic               cmd_tag,
    input  logic [FRAME_W-1:0] cmd_data,
    input  logic [DIV_W-1:0]   cfg_half,
    input  logic               bus_cyc,
    input  logic               freeze,
    input  logic               dso,
    output logic               bkpt_clk_n,
    output logic               dsi,
    output logic [FRAME_W-1:0] rx_data,
    output logic               busy,
    output logic               done,
    output logic               timeout
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        dbgh_state_e        st;
        logic               line;
        logic               dsi;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic [BIT_W-1:0]   bitn;
        logic               dso_ref;
        logic               cyc;
        logic               busy;
        logic               done;
        logic               tmo;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, line: 1'b1, dsi: 1'b0, tx: '0, rx: '0, bitn: '0,
        dso_ref: 1'b0, cyc: 1'b0, busy: 1'b0, done: 1'b0, tmo: 1'b0
    };

    regs_t r_d, r_q;
    logic  accept;
    logic  phase_end;
    logic  tmo_expire;

    assign accept = (r_q.st == ST_IDLE) && cmd_valid;

    dbgh_phase_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (accept),
        .run       ((r_q.st == ST_SH_LO) || (r_q.st == ST_SH_HI)),
        .half      (cfg_half),
        .phase_end (phase_end)
    );

    dbgh_timeout #(.LIMIT(TMO_CYC)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.st == ST_WAIT_DSO),
        .expire (tmo_expire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.cyc  = bus_cyc;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.tmo  = 1'b0;
                    r_d.busy = 1'b1;
                    if (cmd_force) begin
                        r_d.st   = ST_FORCE;
                        r_d.line = 1'b0;
                    end else if (cmd_tag) begin
                        r_d.st = ST_TAG_WAIT;
                    end else begin
                        r_d.st   = ST_SH_LO;
                        r_d.line = 1'b0;
                        r_d.dsi  = cmd_data[FRAME_W-1];
                        r_d.tx   = cmd_data << 1;
                        r_d.bitn = '0;
                    end
                end
            end
            ST_FORCE: begin
                if (freeze) begin
                    r_d.st   = ST_IDLE;
                    r_d.line = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end
            end
            ST_TAG_WAIT: begin
                if (bus_cyc && !r_q.cyc) begin
                    r_d.st   = ST_TAG_LOW;
                    r_d.line = 1'b0;
                end
            end
            ST_TAG_LOW: begin
                if (!bus_cyc) begin
                    r_d.st   = ST_IDLE;
                    r_d.line = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end
            end
            ST_SH_LO: begin
                if (phase_end) begin
                    r_d.line = 1'b1;
                    r_d.rx   = {r_q.rx[FRAME_W-2:0], dso};
                    if (r_q.bitn == LAST_BIT) begin
                        r_d.st      = ST_WAIT_DSO;
                        r_d.dso_ref = dso;
                    end else begin
                        r_d.st = ST_SH_HI;
                    end
                end
            end
            ST_SH_HI: begin
                if (phase_end) begin
                    r_d.st   = ST_SH_LO;
                    r_d.line = 1'b0;
                    r_d.dsi  = r_q.tx[FRAME_W-1];
                    r_d.tx   = r_q.tx << 1;
                    r_d.bitn = r_q.bitn + 1'b1;
                end
            end
            ST_WAIT_DSO: begin
                if (dso != r_q.dso_ref) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else if (tmo_expire) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.tmo  = 1'b1;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign bkpt_clk_n = r_q.line;
    assign dsi        = r_q.dsi;
    assign rx_data    = r_q.rx;
    assign busy       = r_q.busy;
    assign done       = r_q.done;
    assign timeout    = r_q.tmo;

    AST_DSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.line && $past(r_q.line)) |-> $stable(r_q.dsi)); // R6
    AST_WAIT_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_DSO) |-> r_q.line); // R8
    AST_TAG_FOLLOWS_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TAG_LOW) |-> $past(bus_cyc)); // R3
    AST_FORCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_FORCE) && freeze) |=> (r_q.line && done)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.tmo) |-> (!busy && !done)); // R10
endmodule

// File: tb/tb_dbgh_ctrl.sv
module tb_dbgh_ctrl;
    localparam int FW  = 17;
    localparam int DW  = 4;
    localparam int TMO = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_force = 1'b0, cmd_tag = 1'b0;
    logic [FW-1:0] cmd_data = '0;
    logic [DW-1:0] cfg_half = '0;
    logic          bus_cyc = 1'b0, freeze = 1'b0, dso = 1'b0;
    logic          bkpt_clk_n, dsi, busy, done, timeout;
    logic [FW-1:0] rx_data;

    int checks = 0;
    int fails  = 0;
    int cyc_cnt = 0;

    always #2.5 clk = ~clk;

    dbgh_ctrl #(.FRAME_W(FW), .DIV_W(DW), .TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_force(cmd_force),
        .cmd_tag(cmd_tag), .cmd_data(cmd_data), .cfg_half(cfg_half),
        .bus_cyc(bus_cyc), .freeze(freeze), .dso(dso), .bkpt_clk_n(bkpt_clk_n),
        .dsi(dsi), .rx_data(rx_data), .busy(busy), .done(done), .timeout(timeout)
    );

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<150000", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic f, input logic t, input logic [FW-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_force = f; cmd_tag = t; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_force = 1'b0; cmd_tag = 1'b0;
    endtask

    // d < 0: the target never changes dso after the frame
    task automatic do_xfer(input logic [FW-1:0] data, input int half,
                           input logic [FW-1:0] word, input int d);
        int h = half + 1;
        int runl = 0, falls = 0, rises = 0, post = -1, fin = -1;
        int bad_phase = 0, bad_dsi = 0, late_fall = 0;
        logic pl = 1'b1, pdsi;
        logic [FW-1:0] got = '0;
        logic saw_done = 1'b0, saw_tmo = 1'b0;
        int exp_fin = (d >= 0 && d < TMO) ? d + 1 : TMO;
        @(negedge clk);
        cfg_half = DW'(half);
        issue(1'b0, 1'b0, data);
        chk("R10 flag cleared on accept", {31'd0, timeout}, 32'd0);
        pdsi = dsi;
        for (int c = 0; c < 3000 && fin < 0; c++) begin
            if (c > 0) @(negedge clk);
            if (post >= 0 && (done || timeout)) begin
                fin = post; saw_done = done; saw_tmo = timeout;
            end
            if (bkpt_clk_n != pl) begin
                if (c > 0 && runl != h) bad_phase++;
                if (!bkpt_clk_n) begin
                    falls++;
                    if (rises >= FW) late_fall++;
                    if (falls <= FW) dso = word[FW-falls];
                end else begin
                    rises++;
                    if (dsi != pdsi) bad_dsi++;
                    got = {got[FW-2:0], dsi};
                    if (rises == FW) post = 0;
                end
                runl = 1;
            end else begin
                runl++;
                if (dsi != pdsi) bad_dsi++;
            end
            if (post >= 0 && fin < 0) begin
                if (post == d) dso = ~dso;
                post++;
            end
            pl = bkpt_clk_n; pdsi = dsi;
        end
        chk("R5 phase length", bad_phase, 0);
        chk("R5 fall count", falls, FW);
        chk("R5 rise count", rises, FW);
        chk("R6 dsi bit order", {15'd0, got}, {15'd0, data});
        chk("R6 dsi change only at fall", bad_dsi, 0);
        chk("R7 rx_data", {15'd0, rx_data}, {15'd0, word});
        chk("R8 line high after frame", {31'd0, bkpt_clk_n}, 32'd1);
        chk("R8 no fall after frame", late_fall, 0);
        chk(d >= 0 && d < TMO ? "R9 completion clock" : "R10 timeout clock", fin, exp_fin);
        chk("R9 done on change", {31'd0, saw_done}, (d >= 0 && d < TMO) ? 32'd1 : 32'd0);
        chk("R10 timeout flag", {31'd0, saw_tmo}, (d >= 0 && d < TMO) ? 32'd0 : 32'd1);
        chk("R10 busy dropped", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R12 done single clock", {31'd0, done}, 32'd0);
        chk("R10 timeout sticky", {31'd0, timeout}, (d >= 0 && d < TMO) ? 32'd0 : 32'd1);
    endtask

    task automatic do_force(input int n, input logic both);
        int lowc = 0;
        bus_cyc = 1'b0;
        issue(1'b1, both, 17'h0ABCD);
        for (int k = 0; k < n; k++) begin
            if (!bkpt_clk_n) lowc++;
            if (k == 1 && both) bus_cyc = 1'b1;
            @(negedge clk);
        end
        bus_cyc = 1'b0;
        chk(both ? "R4 force priority low" : "R2 force held low", lowc, n);
        freeze = 1'b1;
        @(negedge clk);
        freeze = 1'b0;
        chk(both ? "R4 release line" : "R2 release line", {31'd0, bkpt_clk_n}, 32'd1);
        chk("R2 done on freeze", {31'd0, done}, 32'd1);
        chk("R2 busy drop", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R12 done pulse force", {31'd0, done}, 32'd0);
    endtask

    task automatic do_tag(input int l, input logic pre_high);
        int bad = 0;
        bus_cyc = pre_high;
        issue(1'b0, 1'b1, '0);
        for (int k = 0; k < 3; k++) begin
            if (!bkpt_clk_n) bad++;
            @(negedge clk);
        end
        bus_cyc = 1'b0;
        @(negedge clk);
        if (!bkpt_clk_n) bad++;
        chk("R3 no tag before strobe rise", bad, 0);
        bus_cyc = 1'b1;
        bad = 0;
        for (int k = 1; k <= l; k++) begin
            @(negedge clk);
            if (bkpt_clk_n) bad++;
        end
        bus_cyc = 1'b0;
        chk("R3 low for tagged cycle", bad, 0);
        @(negedge clk);
        chk("R3 line high after cycle", {31'd0, bkpt_clk_n}, 32'd1);
        chk("R3 done after cycle", {31'd0, done}, 32'd1);
        bus_cyc = 1'b1;
        bad = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (!bkpt_clk_n || done) bad++;
        end
        bus_cyc = 1'b0;
        chk("R3 R12 later cycle untagged", bad, 0);
    endtask

    initial begin
        logic [FW-1:0] pats [4] = '{17'h1A5C3, 17'h00001, 17'h10000, 17'h15555};
        repeat (3) @(negedge clk);
        chk("R1 line", {31'd0, bkpt_clk_n}, 32'd1);
        chk("R1 dsi", {31'd0, dsi}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 timeout", {31'd0, timeout}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int h = 0; h < 4; h++) begin
            for (int p = 0; p < 4; p++) begin
                do_xfer(pats[p], h, ~pats[(p + h) % 4], h + p);
            end
        end
        do_xfer(17'h0F0F0, 1, 17'h13579, TMO - 1);
        do_xfer(17'h00F0F, 2, 17'h02468, TMO);
        do_xfer(17'h1FFFF, 0, 17'h00000, -1);
        do_xfer(17'h00000, 3, 17'h1FFFF, 0);

        do_force(1, 1'b0);
        do_force(5, 1'b0);
        do_force(4, 1'b1);
        do_tag(1, 1'b0);
        do_tag(4, 1'b1);

        // R11: commands during a force request are ignored
        issue(1'b1, 1'b0, '0);
        cmd_valid = 1'b1; cmd_data = 17'h1AAAA;
        @(negedge clk);
        cmd_tag = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_tag = 1'b0;
        chk("R11 still forcing", {31'd0, bkpt_clk_n}, 32'd0);
        freeze = 1'b1;
        @(negedge clk);
        freeze = 1'b0;
        chk("R11 done", {31'd0, done}, 32'd1);
        begin
            int bad = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (!bkpt_clk_n || busy) bad++;
            end
            chk("R11 ignored command left no trace", bad, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule